// File: doc/BRIEF.md
# Self-Timed Flash Program and Bulk Erase Sequencer

This block sits behind the command register of a byte-wide non-volatile memory and runs the two write-side operations on its own: byte program and whole-array erase. The host writes a short command sequence over a simple write strobe. From then on the sequencer times every high-voltage pulse, reads the target back, compares it with the expected value, and pulses again until the data matches or a retry budget is used up. The host never times a pulse and never verifies anything itself.

For an erase, the sequencer first drives every location to all zeros, pulsing and verifying each byte in turn. It then applies erase pulses to the whole array at once, with no sector granularity, until every byte reads back as all ones. While an operation is in progress the read port returns a polling byte in place of array data. When the operation ends, the outcome is held in sticky done and fail flags. The array is a behavioural model in which a byte changes only after a configurable number of pulses. Because programming can only clear bits, a program that tries to raise a bit can never verify.

Top module: `flash_seq`

## Requirements
- R1: A write of 0x40 followed by any second write programs the byte at the second write's address with its data. On success, busy_o falls and done_o is set.
- R2: Each program pulse lasts PROG_PW cycles and is followed by one verify cycle. On a byte freshly erased, a program that changes it keeps busy_o high for exactly PROG_NEED*(PROG_PW+1) cycles after the second write is taken.
- R3: Each program pulse can only clear bits. When the byte still differs from the data after PROG_MAX_TRIES pulses, fail_o is set and busy_o falls. The byte then holds the old value ANDed with the data.
- R4: A write of 0x20 followed by a write of 0x20 starts a bulk erase. If the second write carries any other value, the sequence is cancelled: nothing starts, and the next write is treated as a fresh command.
- R5: An erase first programs every byte to 0x00, then applies erase pulses. A successful erase leaves every byte at 0xFF and sets done_o.
- R6: If some byte is not 0xFF after ERASE_MAX_TRIES erase pulses, fail_o is set, busy_o falls, and every byte still reads 0x00.
- R7: The value on rdata_o depends on the state of the block. During a program it is {~data[7], 7'b0}. During an erase it is 0x00. When idle it is the array byte at addr_i.
- R8: Every write taken while busy_o is high is ignored, including a write in the final verify cycle. The command decoder is left unarmed by such writes.
- R9: fail_o stays set until a write of 0xFF arrives with the decoder unarmed and the block idle, which clears both fail_o and done_o. Starting a new operation clears done_o.
- R10: After reset the block is idle, busy_o, done_o and fail_o are 0, and every byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Host write strobe, one cycle per write |
| addr_i | input | AW | Host address for writes and reads |
| wdata_i | input | 8 | Host write data or command byte |
| rdata_o | output | 8 | Array byte when idle, polling byte when busy |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | The last operation verified successfully (sticky) |
| fail_o | output | 1 | A retry budget was used up (sticky) |

## Verification
The sharpest collision is a host write arriving in the same cycle as the final verify, the cycle in which the sequencer decides to leave busy. The bench programs a freshly erased byte and counts the cycles from the pulse width and the pulses the array needs. It then drives a program-setup write into exactly that last busy cycle, and confirms at that moment that busy_o is still high and that it falls at the next edge. The write is judged ignored if a following plain write leaves the array unchanged, which shows the decoder was never armed.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int unsigned DW = 8;

  localparam logic [DW-1:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [DW-1:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [DW-1:0] CMD_ERASE_GO    = 8'h20;
  localparam logic [DW-1:0] CMD_CLEAR       = 8'hFF;

  typedef enum logic [1:0] {
    CMD_READY,
    CMD_PROG_ARMED,
    CMD_ERASE_ARMED
  } cmd_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PPULSE,
    SQ_PVERIFY,
    SQ_EPULSE,
    SQ_EVERIFY
  } seq_state_e;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic          start_prog_o,
  output logic          start_erase_o,
  output logic          clear_o
);
  cmd_state_e state_q, state_d;
  logic accept;

  assign accept = wr_i && !busy_i;

  always_comb begin
    state_d       = state_q;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    clear_o       = 1'b0;
    if (accept) begin
      unique case (state_q)
        CMD_READY: begin
          if (wdata_i == CMD_PROG_SETUP)       state_d = CMD_PROG_ARMED;
          else if (wdata_i == CMD_ERASE_SETUP) state_d = CMD_ERASE_ARMED;
          else if (wdata_i == CMD_CLEAR)       clear_o = 1'b1;
        end
        CMD_PROG_ARMED: begin
          start_prog_o = 1'b1;
          state_d      = CMD_READY;
        end
        CMD_ERASE_ARMED: begin
          start_erase_o = (wdata_i == CMD_ERASE_GO);
          state_d       = CMD_READY;
        end
        default: state_d = CMD_READY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CMD_READY;
    else         state_q <= state_d;
  end

  // R8: host writes during an operation must not move the decoder
  a_r8_busy_holds_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(state_q));
endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned PROG_NEED  = 3,
  parameter int unsigned ERASE_NEED = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] pgm_addr_i,
  input  logic [DW-1:0] pgm_data_i,
  input  logic          prog_stb_i,
  input  logic          erase_stb_i
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PCW   = $clog2(PROG_NEED + 1);
  localparam int unsigned ECW   = $clog2(ERASE_NEED + 1);

  logic [DW-1:0]  mem_q  [DEPTH];
  logic [PCW-1:0] pcnt_q [DEPTH];
  logic [ECW-1:0] ecnt_q;
  logic [DW-1:0]  old_cell;
  logic           all_zero;

  assign rdata_o  = mem_q[rd_addr_i];
  assign old_cell = mem_q[pgm_addr_i];

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < DEPTH; i++) all_zero &= (mem_q[i] == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i]  <= '1;
        pcnt_q[i] <= '0;
      end
    end else if (erase_stb_i) begin
      if (ecnt_q == ECW'(ERASE_NEED - 1)) begin
        ecnt_q <= '0;
        for (int i = 0; i < DEPTH; i++) begin
          mem_q[i]  <= '1;
          pcnt_q[i] <= '0;
        end
      end else begin
        ecnt_q <= ecnt_q + 1'b1;
      end
    end else if (prog_stb_i) begin
      if (pcnt_q[pgm_addr_i] == PCW'(PROG_NEED - 1)) begin
        pcnt_q[pgm_addr_i] <= '0;
        mem_q[pgm_addr_i]  <= mem_q[pgm_addr_i] & pgm_data_i;
      end else begin
        pcnt_q[pgm_addr_i] <= pcnt_q[pgm_addr_i] + 1'b1;
      end
    end
  end

  // R3: a program pulse never raises a bit
  a_r3_no_bit_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_stb_i && !erase_stb_i) |=> ((mem_q[$past(pgm_addr_i)] & ~$past(old_cell)) == '0));

  // R5: erase pulses only ever hit a fully pre-programmed array
  a_r5_erase_after_preprog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_stb_i |-> all_zero);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned PROG_PW     = 16,
  parameter int unsigned ERASE_PW    = 64,
  parameter int unsigned PROG_MAX    = 25,
  parameter int unsigned ERASE_MAX   = 1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_prog_i,
  input  logic          start_erase_i,
  input  logic          clear_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] arr_rdata_i,
  output logic [AW-1:0] arr_addr_o,
  output logic [DW-1:0] arr_wdata_o,
  output logic          prog_stb_o,
  output logic          erase_stb_o,
  output logic          busy_o,
  output logic          erasing_o,
  output logic          done_o,
  output logic          fail_o
);
  localparam int unsigned MAXPW = (PROG_PW > ERASE_PW) ? PROG_PW : ERASE_PW;
  localparam int unsigned MAXT  = (PROG_MAX > ERASE_MAX) ? PROG_MAX : ERASE_MAX;
  localparam int unsigned PWW   = $clog2(MAXPW + 1);
  localparam int unsigned TW    = $clog2(MAXT + 1);
  localparam logic [PWW-1:0] PPW_END = PWW'(PROG_PW - 1);
  localparam logic [PWW-1:0] EPW_END = PWW'(ERASE_PW - 1);

  seq_state_e     state_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [PWW-1:0] pw_q;
  logic [TW-1:0]  tries_q;
  logic           erase_q, done_q, fail_q;
  logic           last_addr;

  assign last_addr   = (addr_q == {AW{1'b1}});
  assign arr_addr_o  = addr_q;
  assign arr_wdata_o = data_q;
  assign prog_stb_o  = (state_q == SQ_PPULSE) && (pw_q == PPW_END);
  assign erase_stb_o = (state_q == SQ_EPULSE) && (pw_q == EPW_END);
  assign busy_o      = (state_q != SQ_IDLE);
  assign erasing_o   = erase_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      pw_q    <= '0;
      tries_q <= '0;
      erase_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (clear_i) begin
            fail_q <= 1'b0;
            done_q <= 1'b0;
          end
          if (start_prog_i || start_erase_i) begin
            state_q <= SQ_PPULSE;
            pw_q    <= '0;
            tries_q <= '0;
            done_q  <= 1'b0;
            erase_q <= start_erase_i;
            addr_q  <= start_erase_i ? '0 : addr_i;
            data_q  <= start_erase_i ? '0 : data_i;
          end
        end
        SQ_PPULSE: begin
          if (pw_q == PPW_END) begin
            pw_q    <= '0;
            tries_q <= tries_q + 1'b1;
            state_q <= SQ_PVERIFY;
          end else begin
            pw_q <= pw_q + 1'b1;
          end
        end
        SQ_PVERIFY: begin
          if (arr_rdata_i == data_q) begin
            tries_q <= '0;
            if (!erase_q) begin
              done_q  <= 1'b1;
              state_q <= SQ_IDLE;
            end else if (last_addr) begin
              addr_q  <= '0;
              state_q <= SQ_EPULSE;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= SQ_PPULSE;
            end
          end else if (tries_q == TW'(PROG_MAX)) begin
            fail_q  <= 1'b1;
            erase_q <= 1'b0;
            state_q <= SQ_IDLE;
          end else begin
            state_q <= SQ_PPULSE;
          end
        end
        SQ_EPULSE: begin
          if (pw_q == EPW_END) begin
            pw_q    <= '0;
            tries_q <= tries_q + 1'b1;
            state_q <= SQ_EVERIFY;
          end else begin
            pw_q <= pw_q + 1'b1;
          end
        end
        SQ_EVERIFY: begin
          // resume scan from the first byte that failed; erased bytes stay erased
          if (arr_rdata_i == {DW{1'b1}}) begin
            if (last_addr) begin
              done_q  <= 1'b1;
              erase_q <= 1'b0;
              state_q <= SQ_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
            end
          end else if (tries_q == TW'(ERASE_MAX)) begin
            fail_q  <= 1'b1;
            erase_q <= 1'b0;
            state_q <= SQ_IDLE;
          end else begin
            state_q <= SQ_EPULSE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  a_r3_prog_tries_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_PVERIFY) |-> (tries_q <= TW'(PROG_MAX)));

  a_r6_erase_tries_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_EVERIFY) |-> (tries_q <= TW'(ERASE_MAX)));

  a_r2_verify_after_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_PVERIFY) |-> ($past(state_q) == SQ_PPULSE));

  a_r9_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !clear_i) |=> fail_q);
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned PROG_PW    = 16,
  parameter int unsigned ERASE_PW   = 64,
  parameter int unsigned PROG_MAX   = 25,
  parameter int unsigned ERASE_MAX  = 1000,
  parameter int unsigned PROG_NEED  = 3,
  parameter int unsigned ERASE_NEED = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o
);
  logic          start_prog, start_erase, clear;
  logic          busy, erasing;
  logic [AW-1:0] seq_addr, rd_addr;
  logic [DW-1:0] seq_wdata, arr_rdata;
  logic          prog_stb, erase_stb;

  flash_cmd_decode u_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .wdata_i       (wdata_i),
    .busy_i        (busy),
    .start_prog_o  (start_prog),
    .start_erase_o (start_erase),
    .clear_o       (clear)
  );

  flash_seq_fsm #(
    .AW        (AW),
    .PROG_PW   (PROG_PW),
    .ERASE_PW  (ERASE_PW),
    .PROG_MAX  (PROG_MAX),
    .ERASE_MAX (ERASE_MAX)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_prog_i  (start_prog),
    .start_erase_i (start_erase),
    .clear_i       (clear),
    .addr_i        (addr_i),
    .data_i        (wdata_i),
    .arr_rdata_i   (arr_rdata),
    .arr_addr_o    (seq_addr),
    .arr_wdata_o   (seq_wdata),
    .prog_stb_o    (prog_stb),
    .erase_stb_o   (erase_stb),
    .busy_o        (busy),
    .erasing_o     (erasing),
    .done_o        (done_o),
    .fail_o        (fail_o)
  );

  assign rd_addr = busy ? seq_addr : addr_i;

  flash_array_model #(
    .AW         (AW),
    .PROG_NEED  (PROG_NEED),
    .ERASE_NEED (ERASE_NEED)
  ) u_arr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_addr_i   (rd_addr),
    .rdata_o     (arr_rdata),
    .pgm_addr_i  (seq_addr),
    .pgm_data_i  (seq_wdata),
    .prog_stb_i  (prog_stb),
    .erase_stb_i (erase_stb)
  );

  always_comb begin
    if (!busy)        rdata_o = arr_rdata;
    else if (erasing) rdata_o = '0;
    else              rdata_o = {~seq_wdata[7], 7'b0};
  end

  assign busy_o = busy;
endmodule

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PPW   = 3;
  localparam int EPW   = 5;
  localparam int PMAX  = 5;
  localparam int EMAX  = 6;
  localparam int PNEED = 2;
  localparam int ENEED = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic sel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_m, rd_e;
  logic busy_m, done_m, fail_m, busy_e, done_e, fail_e;
  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] img [DEPTH];

  always #2.5 clk = ~clk;

  flash_seq #(.AW(AW), .PROG_PW(PPW), .ERASE_PW(EPW), .PROG_MAX(PMAX),
              .ERASE_MAX(EMAX), .PROG_NEED(PNEED), .ERASE_NEED(ENEED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr & ~sel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_m), .busy_o(busy_m), .done_o(done_m), .fail_o(fail_m));

  // erase can never complete here: needs more pulses than the budget
  flash_seq #(.AW(AW), .PROG_PW(PPW), .ERASE_PW(EPW), .PROG_MAX(PMAX),
              .ERASE_MAX(EMAX), .PROG_NEED(PNEED), .ERASE_NEED(EMAX + 2)) u_dut_ef (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr & sel), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd_e), .busy_o(busy_e), .done_o(done_e), .fail_o(fail_e));

  function automatic logic busy_s(); return sel ? busy_e : busy_m; endfunction
  function automatic logic done_s(); return sel ? done_e : done_m; endfunction
  function automatic logic fail_s(); return sel ? fail_e : fail_m; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #0.5;
    v = sel ? rd_e : rd_m;
  endtask

  task automatic wait_idle();
    while (busy_s()) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R8 busy stuck actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, d1, d2, exp_v;
    bit exp_fail;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    @(negedge clk);
    chk(busy_m == 0 && done_m == 0 && fail_m == 0, "R10 flags after reset",
        {busy_m, done_m, fail_m}, 0);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      chk(v == 8'hFF, "R10 erased after reset", v, 8'hFF);
    end

    // R1 / R7 / R9: program every byte, check polling byte while busy
    for (int a = 0; a < DEPTH; a++) begin
      d1 = 8'((a * 37 + 5) & 8'hFF);
      img[a] = d1;
      host_write(a[AW-1:0], 8'h40);
      host_write(a[AW-1:0], d1);
      chk(busy_m == 1, "R1 busy after program start", busy_m, 1);
      chk(done_m == 0, "R9 done cleared on start", done_m, 0);
      chk(rd_m == {~d1[7], 7'b0}, "R7 polling byte during program", rd_m, {~d1[7], 7'b0});
      wait_idle();
      chk(done_m == 1 && fail_m == 0, "R1 done after program", {done_m, fail_m}, 2);
    end
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      chk(v == img[a], "R1 programmed data", v, img[a]);
      chk(v == img[a], "R7 idle read returns array", v, img[a]);
    end

    // R3 / R9: overwrite sweep, bits can only clear; raising a bit fails
    for (int a = 0; a < DEPTH; a++) begin
      d1 = img[a];
      d2 = 8'((a * 11 + 8'h93) & 8'hFF);
      exp_v = d1 & d2;
      exp_fail = ((d2 & ~d1) != 0);
      host_write(a[AW-1:0], 8'h40);
      host_write(a[AW-1:0], d2);
      wait_idle();
      chk(fail_m == exp_fail, "R3 fail flag on overwrite", fail_m, exp_fail);
      chk(done_m == !exp_fail, "R3 done flag on overwrite", done_m, !exp_fail);
      rd(a[AW-1:0], v);
      chk(v == exp_v, "R3 cell holds old AND data", v, exp_v);
      img[a] = exp_v;
      if (exp_fail) begin
        repeat (4) @(negedge clk);
        chk(fail_m == 1, "R9 fail stays set", fail_m, 1);
        host_write(0, 8'hFF);
        chk(fail_m == 0 && done_m == 0, "R9 clear command", {fail_m, done_m}, 0);
      end
    end

    // R4: erase setup then non-confirm cancels; next write is fresh
    host_write(0, 8'h20);
    host_write(0, 8'h00);
    chk(busy_m == 0, "R4 cancelled erase does not start", busy_m, 0);
    host_write(3, 8'h00);
    repeat (30) @(negedge clk);
    rd(3, v);
    chk(v == img[3], "R4 plain write after cancel has no effect", v, img[3]);

    // R5 / R7 / R8: bulk erase, commands during busy ignored
    host_write(0, 8'h20);
    host_write(0, 8'h20);
    chk(busy_m == 1, "R5 erase started", busy_m, 1);
    chk(rd_m == 8'h00, "R7 polling byte during erase", rd_m, 0);
    host_write(5, 8'h40);
    host_write(5, 8'h00);
    wait_idle();
    chk(done_m == 1 && fail_m == 0, "R5 erase done", {done_m, fail_m}, 2);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      chk(v == 8'hFF, "R5 all bytes erased", v, 8'hFF);
    end
    host_write(6, 8'h12);
    repeat (30) @(negedge clk);
    rd(6, v);
    chk(v == 8'hFF, "R8 writes during erase left decoder unarmed", v, 8'hFF);

    // R2 / R8: exact program duration; write in last verify cycle is dropped
    host_write(2, 8'h40);
    host_write(2, 8'h5A);
    repeat (PNEED * (PPW + 1) - 1) @(negedge clk);
    chk(busy_m == 1, "R2 busy in final verify cycle", busy_m, 1);
    wr = 1'b1; addr = 9; wdata = 8'h40;
    @(negedge clk);
    wr = 1'b0;
    chk(busy_m == 0, "R2 busy falls after N cycles", busy_m, 0);
    host_write(9, 8'h00);
    repeat (30) @(negedge clk);
    rd(9, v);
    chk(v == 8'hFF, "R8 write in final cycle ignored", v, 8'hFF);
    rd(2, v);
    chk(v == 8'h5A, "R1 program after erase", v, 8'h5A);

    // R6: erase that exhausts its budget
    sel = 1'b1;
    host_write(0, 8'h20);
    host_write(0, 8'h20);
    wait_idle();
    chk(fail_e == 1 && done_e == 0, "R6 erase budget exhausted", {fail_e, done_e}, 2);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a[AW-1:0], v);
      chk(v == 8'h00, "R6 bytes left pre-programmed", v, 0);
    end
    chk(fail_s() == 1 && done_s() == 0, "R9 fail sticky on second unit",
        {fail_s(), done_s()}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule